// File: doc/BRIEF.md
# Sign-Magnitude Iterative Integer Divider

This unit computes integer division and modulus for a 64-bit processor pipeline over many cycles. The issuing stage has already reduced both operands to non-negative magnitudes and has worked out the sign the result must carry. It presents one request per operation on a valid-qualified input. Each request carries the two magnitudes, a 32-bit mode flag, an extended-form flag, a flag that selects the remainder instead of the quotient, a negate flag and a destination tag with a record bit.

The unit runs a restoring shift-subtract loop that produces one quotient bit per cycle. It then picks the quotient or the remainder, negates it in two's complement when asked, and returns it with a one-cycle `done` pulse and the tag and record bit it captured. The issuing stage keeps only one operation in flight. `busy` lets it see that, and a request made while `busy` is high is dropped.

Top module: `sm_div_unit`

## Requirements
- R1: With the remainder flag clear, the result is the unsigned quotient of the dividend magnitude by the divisor magnitude. In 64-bit non-extended form both operands use all 64 bits.
- R2: With the remainder flag set, the result is the unsigned remainder of the same division.
- R3: With the negate flag set, the result is the two's-complement negation of the selected quotient or remainder.
- R4: In the 64-bit extended form, the effective dividend is the 64-bit input followed by 64 zero bits. If the quotient does not fit in 64 bits (dividend >= divisor), the result is zero, whether the quotient or the remainder was selected.
- R5: In 32-bit mode only bits 31:0 of the divisor are used, and the result is bits 31:0 of the signed result with bits 63:32 zero. Non-extended requests use dividend bits 31:0. Extended requests take the full 64-bit dividend, which holds its magnitude in bits 63:32. If that quotient does not fit in 32 bits, the result is zero.
- R6: A zero divisor gives a result of zero after the normal latency.
- R7: `done` is a pulse one cycle wide. It rises 33 clock edges after the accepting edge for non-extended 32-bit requests and 65 edges after it for every other form.
- R8: `res_tag` and `res_record` return, while `done` is high, the tag and record bit captured with the request.
- R9: `busy` is high from the edge after acceptance until the `done` cycle, in which it is low. A request presented while `busy` is high is ignored: it produces neither a second `done` nor a change to the pending result.
- R10: An asynchronous active-low reset clears `busy`, `done`, `res_value`, `res_tag` and `res_record` to zero and abandons any operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_dividend | input | 64 | Dividend magnitude |
| req_divisor | input | 64 | Divisor magnitude |
| req_word32 | input | 1 | 32-bit operation |
| req_extended | input | 1 | Extended form (dividend shifted up by the word width) |
| req_remainder | input | 1 | Return the remainder instead of the quotient |
| req_negate | input | 1 | Negate the returned value |
| req_tag | input | 5 | Destination register tag |
| req_record | input | 1 | Record-condition bit |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| res_value | output | 64 | Result value |
| res_tag | output | 5 | Returned destination tag |
| res_record | output | 1 | Returned record bit |

## Verification
Most internal faults in this unit show up as a wrong `res_value` or as a `done` pulse at the wrong time. A stuck or miscounted iteration counter moves `done` off the 33-cycle or 65-cycle mark, or it never lets `busy` fall. A wrong initial split of the remainder and quotient registers corrupts the extended and 32-bit results, and that error is visible at the first `done`. A bad capture of the mode or tag appears in the same cycle as `done`. A fault in the busy guard appears as an extra `done` or a corrupted pending result within one operation's latency.

// File: rtl/sm_div_pkg.sv
package sm_div_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_FINISH = 2'd2
  } div_state_e;

  typedef struct packed {
    logic word32;
    logic sel_rem;
    logic negate;
    logic force_zero;
  } div_mode_t;

endpackage

// File: rtl/sm_div_ctrl.sv
module sm_div_ctrl
  import sm_div_pkg::*;
#(
  parameter int ITER_FULL = 64,
  parameter int ITER_HALF = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic half_len,
  output logic busy,
  output logic step,
  output logic finish,
  output logic done
);

  localparam int CNT_W = $clog2(ITER_FULL + 1);

  div_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_RUN;
          cnt_d   = half_len ? CNT_W'(ITER_HALF) : CNT_W'(ITER_FULL);
        end
      end
      ST_RUN: begin
        cnt_d = cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) state_d = ST_FINISH;
      end
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
    done_d = (state_q == ST_FINISH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign busy   = (state_q != ST_IDLE);
  assign step   = (state_q == ST_RUN);
  assign finish = (state_q == ST_FINISH);
  assign done   = done_q;

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  run_cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> (cnt_q != '0));

endmodule

// File: rtl/sm_div_core.sv
module sm_div_core #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] init_rem,
  input  logic [W-1:0] init_quo,
  input  logic [W-1:0] init_dsr,
  output logic [W-1:0] rem_val,
  output logic [W-1:0] quo_val
);

  logic [W-1:0] rem_q, rem_d;
  logic [W-1:0] quo_q, quo_d;
  logic [W-1:0] dsr_q, dsr_d;
  logic [W:0]   shifted;
  logic [W:0]   diff;
  logic         fits;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    diff    = shifted - {1'b0, dsr_q};
    fits    = (shifted >= {1'b0, dsr_q});
    rem_d   = rem_q;
    quo_d   = quo_q;
    dsr_d   = dsr_q;
    if (load) begin
      rem_d = init_rem;
      quo_d = init_quo;
      dsr_d = init_dsr;
    end else if (step) begin
      rem_d = fits ? diff[W-1:0] : shifted[W-1:0];
      quo_d = {quo_q[W-2:0], fits};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dsr_q <= '0;
    end else if (load || step) begin
      rem_q <= rem_d;
      quo_q <= quo_d;
      dsr_q <= dsr_d;
    end
  end

  assign rem_val = rem_q;
  assign quo_val = quo_q;

endmodule

// File: rtl/sm_div_result.sv
module sm_div_result
  import sm_div_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] rem_val,
  input  logic [W-1:0] quo_val,
  input  div_mode_t    mode,
  output logic [W-1:0] value
);

  localparam int HALF = W / 2;

  logic [W-1:0] picked;
  logic [W-1:0] signed_val;

  always_comb begin
    picked     = mode.sel_rem ? rem_val : quo_val;
    signed_val = mode.negate ? (~picked + W'(1)) : picked;
    if (mode.force_zero) begin
      value = '0;
    end else if (mode.word32) begin
      value = {{(W-HALF){1'b0}}, signed_val[HALF-1:0]};
    end else begin
      value = signed_val;
    end
  end

endmodule

// File: rtl/sm_div_unit.sv
module sm_div_unit
  import sm_div_pkg::*;
#(
  parameter int W     = 64,
  parameter int TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [W-1:0]     req_dividend,
  input  logic [W-1:0]     req_divisor,
  input  logic             req_word32,
  input  logic             req_extended,
  input  logic             req_remainder,
  input  logic             req_negate,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             req_record,
  output logic             busy,
  output logic             done,
  output logic [W-1:0]     res_value,
  output logic [TAG_W-1:0] res_tag,
  output logic             res_record
);

  localparam int HALF = W / 2;

  logic             accept;
  logic             step;
  logic             finish;
  logic             half_len;
  logic [W-1:0]     dsr_eff;
  logic             overflow;
  logic [W-1:0]     init_rem;
  logic [W-1:0]     init_quo;
  logic [W-1:0]     rem_val;
  logic [W-1:0]     quo_val;
  logic [W-1:0]     value;
  div_mode_t        mode_d, mode_q;
  logic [TAG_W-1:0] tag_q;
  logic             rec_q;
  logic [W-1:0]     res_value_q;
  logic [TAG_W-1:0] res_tag_q;
  logic             res_record_q;

  assign accept   = req_valid && !busy;
  assign half_len = req_word32 && !req_extended;

  // Operand preparation for the chosen form
  always_comb begin
    dsr_eff = req_word32 ? {{(W-HALF){1'b0}}, req_divisor[HALF-1:0]} : req_divisor;
    if (!req_extended)
      overflow = 1'b0;
    else if (req_word32)
      overflow = ({{(W-HALF){1'b0}}, req_dividend[W-1:HALF]} >= dsr_eff);
    else
      overflow = (req_dividend >= dsr_eff);

    if (req_extended && !req_word32) begin
      init_rem = req_dividend;
      init_quo = '0;
    end else if (half_len) begin
      init_rem = '0;
      init_quo = {req_dividend[HALF-1:0], {(W-HALF){1'b0}}};
    end else begin
      init_rem = '0;
      init_quo = req_dividend;
    end

    mode_d.word32     = req_word32;
    mode_d.sel_rem    = req_remainder;
    mode_d.negate     = req_negate;
    mode_d.force_zero = overflow || (dsr_eff == '0);
  end

  sm_div_ctrl #(
    .ITER_FULL(W),
    .ITER_HALF(HALF)
  ) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .half_len(half_len),
    .busy    (busy),
    .step    (step),
    .finish  (finish),
    .done    (done)
  );

  sm_div_core #(
    .W(W)
  ) core_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .step    (step),
    .init_rem(init_rem),
    .init_quo(init_quo),
    .init_dsr(dsr_eff),
    .rem_val (rem_val),
    .quo_val (quo_val)
  );

  sm_div_result #(
    .W(W)
  ) result_i (
    .rem_val(rem_val),
    .quo_val(quo_val),
    .mode   (mode_q),
    .value  (value)
  );

  // Request capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      tag_q  <= '0;
      rec_q  <= 1'b0;
    end else if (accept) begin
      mode_q <= mode_d;
      tag_q  <= req_tag;
      rec_q  <= req_record;
    end
  end

  // Result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_value_q  <= '0;
      res_tag_q    <= '0;
      res_record_q <= 1'b0;
    end else if (finish) begin
      res_value_q  <= value;
      res_tag_q    <= tag_q;
      res_record_q <= rec_q;
    end
  end

  assign res_value  = res_value_q;
  assign res_tag    = res_tag_q;
  assign res_record = res_record_q;

  // R9
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  // R9
  accept_to_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);

  // R5
  word32_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q.word32) |-> (res_value[W-1:HALF] == '0));

  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

endmodule

// File: tb/sm_div_unit_tb.sv
module sm_div_unit_tb_top;

  typedef struct packed {
    logic [63:0] dd;
    logic [63:0] ds;
    logic        w32;
    logic        ext;
    logic        rem;
    logic        neg;
    logic        rec;
    logic [4:0]  tag;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VT [NV] = '{
    '{64'd100, 64'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd1},                       // R1
    '{64'd100, 64'd7, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 5'd2},                       // R2
    '{64'd100, 64'd7, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'd3},                       // R3
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd4},       // R1
    '{64'h1234_5678_9ABC_DEF0, 64'h1_0000_0001, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 5'd5}, // R2 R3
    '{64'd1, 64'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd6},                         // R4
    '{64'd5, 64'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 5'd7},                         // R4 overflow
    '{64'd2, 64'd7, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 5'd8},                         // R4 remainder
    '{64'd1000, 64'd7, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 5'd9},                      // R5
    '{64'h0000_0001_0000_0000, 64'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd10},      // R5 extended
    '{64'h0000_0009_0000_0000, 64'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 5'd11},      // R5 overflow
    '{64'd55, 64'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 5'd12},                       // R6
    '{64'hFFFF_FFFF, 64'd10, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 5'd13},               // R5 remainder
    '{64'd77, 64'hFFFF_FFFF_0000_0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd14}      // R6 word32 zero low divisor
  };

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [63:0] req_dividend;
  logic [63:0] req_divisor;
  logic        req_word32;
  logic        req_extended;
  logic        req_remainder;
  logic        req_negate;
  logic [4:0]  req_tag;
  logic        req_record;
  logic        busy;
  logic        done;
  logic [63:0] res_value;
  logic [4:0]  res_tag;
  logic        res_record;

  int checks;
  int fails;

  sm_div_unit dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_dividend (req_dividend),
    .req_divisor  (req_divisor),
    .req_word32   (req_word32),
    .req_extended (req_extended),
    .req_remainder(req_remainder),
    .req_negate   (req_negate),
    .req_tag      (req_tag),
    .req_record   (req_record),
    .busy         (busy),
    .done         (done),
    .res_value    (res_value),
    .res_tag      (res_tag),
    .res_record   (res_record)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [63:0] model(vec_t v);
    logic [127:0] num, den, q, r;
    logic [63:0]  sel;
    logic         z;
    if (v.w32) begin
      den = {96'd0, v.ds[31:0]};
      num = v.ext ? {64'd0, v.dd} : {96'd0, v.dd[31:0]};
    end else begin
      den = {64'd0, v.ds};
      num = v.ext ? {v.dd, 64'd0} : {64'd0, v.dd};
    end
    if (den == 128'd0) begin
      q = '0;
      r = '0;
      z = 1'b1;
    end else begin
      q = num / den;
      r = num % den;
      z = v.w32 ? (q[127:32] != '0) : (q[127:64] != '0);
    end
    sel = v.rem ? r[63:0] : q[63:0];
    if (v.neg) sel = ~sel + 64'd1;
    if (v.w32) sel = {32'd0, sel[31:0]};
    if (z) sel = '0;
    return sel;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive_idle();
    req_valid     = 1'b0;
    req_dividend  = '0;
    req_divisor   = '0;
    req_word32    = 1'b0;
    req_extended  = 1'b0;
    req_remainder = 1'b0;
    req_negate    = 1'b0;
    req_tag       = '0;
    req_record    = 1'b0;
  endtask

  task automatic drive_req(input vec_t v);
    req_valid     = 1'b1;
    req_dividend  = v.dd;
    req_divisor   = v.ds;
    req_word32    = v.w32;
    req_extended  = v.ext;
    req_remainder = v.rem;
    req_negate    = v.neg;
    req_tag       = v.tag;
    req_record    = v.rec;
  endtask

  // Returns edges after the accepting edge until done is seen
  task automatic run_op(input vec_t v, output int lat, output logic bz);
    @(negedge clk);
    drive_req(v);
    @(negedge clk);
    drive_idle();
    bz  = busy;
    lat = 0;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int   lat;
    logic bz;
    int   extra;
    checks = 0;
    fails  = 0;
    drive_idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);

    // R10 reset state
    check(!busy && !done, "R10", "busy/done in reset", {busy, done}, 64'd0);
    check(res_value == '0 && res_tag == '0 && !res_record, "R10", "result in reset",
          res_value, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      automatic vec_t v = VT[i];
      automatic int   exp_lat = (v.w32 && !v.ext) ? 33 : 65;
      run_op(v, lat, bz);
      // R9 busy after acceptance
      check(bz == 1'b1, "R9", "busy after accept", {63'd0, bz}, 64'd1);
      // R7 latency
      check(lat == exp_lat, "R7", "done latency", lat, exp_lat);
      // R1 R2 R3 R4 R5 R6 value
      check(res_value == model(v), "R1-R6 value", $sformatf("vector %0d", i),
            res_value, model(v));
      // R8 tag and record
      check(res_tag == v.tag && res_record == v.rec, "R8", "tag/record",
            {58'd0, res_record, res_tag}, {58'd0, v.rec, v.tag});
      // R9 busy low in done cycle
      check(!busy, "R9", "busy low with done", {63'd0, busy}, 64'd0);
      @(negedge clk);
      // R7 one-cycle pulse
      check(!done, "R7", "done pulse width", {63'd0, done}, 64'd0);
    end

    // R9 request while busy is ignored
    begin
      automatic vec_t a = VT[0];
      automatic vec_t b = '{64'd999, 64'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd30};
      @(negedge clk);
      drive_req(a);
      @(negedge clk);
      drive_idle();
      repeat (5) @(negedge clk);
      drive_req(b);
      @(negedge clk);
      drive_idle();
      lat = 6;
      while (!done && lat < 200) begin
        @(negedge clk);
        lat++;
      end
      check(lat == 65, "R9", "latency unaffected by busy request", lat, 65);
      check(res_value == 64'd14 && res_tag == 5'd1, "R9", "busy request ignored",
            res_value, 64'd14);
      extra = 0;
      for (int k = 0; k < 80; k++) begin
        @(negedge clk);
        if (done) extra++;
      end
      check(extra == 0, "R9", "no second done", extra, 0);
      check(res_value == 64'd14, "R9", "result held", res_value, 64'd14);
    end

    // R10 reset abandons an operation
    begin
      @(negedge clk);
      drive_req(VT[3]);
      @(negedge clk);
      drive_idle();
      repeat (10) @(negedge clk);
      rst_n = 1'b0;
      #1;
      check(!busy && !done, "R10", "mid-op reset busy/done", {busy, done}, 64'd0);
      check(res_value == '0 && res_tag == '0 && !res_record, "R10", "mid-op reset result",
            res_value, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      extra = 0;
      for (int k = 0; k < 80; k++) begin
        @(negedge clk);
        if (done || busy) extra++;
      end
      check(extra == 0, "R10", "no activity after reset", extra, 0);
    end

    // R6 zero divisor in 32-bit extended form, quotient with negate
    begin
      automatic vec_t z = '{64'h0000_0003_0000_0000, 64'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 5'd21};
      run_op(z, lat, bz);
      check(lat == 65, "R6", "zero divisor latency", lat, 65);
      check(res_value == 64'd0, "R6", "zero divisor result", res_value, 64'd0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule